// File: doc/BRIEF.md
# Row/Column Conflict-Free Matrix Store

This block keeps an N-by-N matrix of data words (8x8 by default) and moves a whole row or a whole column of it in a single clock cycle. A slice request names a direction (row or column) and an index. In the same cycle the block can write the N lanes of the write bus into that slice and read the slice's current content. The read content appears on the read bus one cycle later. A custom functional unit that runs one-dimensional passes can therefore issue one slice per cycle. A full two-dimensional pass takes 2N back-to-back operations: first every row, then every column.

The storage is N independent single-port banks of N flip-flop words each. Element (r,c) lives in bank (r+c) mod N at address r. With this skewed placement, every row and every column uses each bank exactly once, so neither direction has a bank conflict. A rotation stage in front of the banks spreads the write lanes onto their banks. A second rotation stage after the banks gathers the read words back into element order. The rotation amount in both directions is the slice index.

The slice interface is a fixed-latency port with no back-pressure. A request is taken on every clock edge and cannot be refused. The data it reads is valid exactly one cycle later.

Top module: `mstore_rowcol`

## Requirements
- R1: While reset is asserted, and after reset is released, every element reads as zero, and the read bus is zero.
- R2: The read bus in the cycle after a request carries the slice that was named in that request. Requests may be issued on every cycle with no idle cycle between them.
- R3: A row request with index i (slice_col=0) returns element (i,k) on lane k. Element (r,c) has linear index N*r+c. Lane k occupies read bus bits [k*DW +: DW].
- R4: A column request with index j (slice_col=1) returns element (k,j) on lane k. It uses the same lane bit positions as R3.
- R5: A write to row i stores lane k into element (i,k). A write to column j stores lane k into element (k,j).
- R6: Data written through one direction reads back correctly through the other, so a write by rows followed by a read by columns gives the transpose view.
- R7: When a slice is read and written in the same cycle, the read returns the content from before the write. The new content is visible to a request in the following cycle.
- R8: When wr_en is low, no element changes, whatever is on the write bus.
- R9: Every slice access uses each bank once. A row access drives address i on every bank. A column access drives each address 0..N-1 on exactly one bank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, clears all elements |
| slice_col | input | 1 | Slice direction: 0 selects a row, 1 selects a column |
| slice_idx | input | log2(N) | Row or column index of the slice |
| wr_en | input | 1 | Write the write bus into the named slice this cycle |
| wr_data | input | N*DW | Write lanes, lane k at bits [k*DW +: DW] |
| rd_data | output | N*DW | Read lanes of the previous cycle's slice, lane k at bits [k*DW +: DW] |

## Verification
A read and a write can fall in the same cycle. They can hit the same slice, or a row and a column that share one element. The bench makes every write operation also a read. It compares the returned lanes with a bench-side matrix model taken before that write is applied, then applies the write to the model, so any early visibility of new data shows up as a mismatch. Back-to-back sequences alternate direction and include repeated writes to one slice. A pseudo-random stream of mixed rows, columns and write enables probes crossing slices in adjacent cycles.

// File: rtl/mstore_pkg.sv
`timescale 1ns/1ps
package mstore_pkg;
  typedef enum logic {
    SLICE_ROW = 1'b0,
    SLICE_COL = 1'b1
  } slice_dir_e;
endpackage

// File: rtl/mstore_bank.sv
`timescale 1ns/1ps
// Single-port flop bank: one address per cycle, registered read of old data.
module mstore_bank #(
  parameter int DEPTH = 8,
  parameter int DW    = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < DEPTH; a++) mem[a] <= '0;
      rdata <= '0;
    end else begin
      rdata <= mem[addr];
      if (we) mem[addr] <= wdata;
    end
  end
endmodule

// File: rtl/mstore_rotate.sv
`timescale 1ns/1ps
// Lane rotation. GATHER=1: out[k] = in[(k+amt) mod N]; GATHER=0: out[k] = in[(k-amt) mod N].
module mstore_rotate #(
  parameter int N      = 8,
  parameter int DW     = 16,
  parameter bit GATHER = 1'b1,
  localparam int SW    = $clog2(N)
) (
  input  logic [N*DW-1:0] din,
  input  logic [SW-1:0]   amt,
  output logic [N*DW-1:0] dout
);
  for (genvar k = 0; k < N; k++) begin : g_lane
    logic [SW-1:0] src;
    if (GATHER) begin : g_gat
      assign src = SW'(k) + amt;
    end else begin : g_sct
      assign src = SW'(k) - amt;
    end
    assign dout[k*DW +: DW] = din[src*DW +: DW];
  end
endmodule

// File: rtl/mstore_addr.sv
`timescale 1ns/1ps
// Per-bank address for the skewed layout: element (r,c) in bank (r+c) mod N at address r.
module mstore_addr #(
  parameter int N   = 8,
  localparam int AW = $clog2(N)
) (
  input  mstore_pkg::slice_dir_e dir,
  input  logic [AW-1:0]          idx,
  output logic [N-1:0][AW-1:0]   addr
);
  for (genvar b = 0; b < N; b++) begin : g_bank
    assign addr[b] = (dir == mstore_pkg::SLICE_ROW) ? idx : (AW'(b) - idx);
  end
endmodule

// File: rtl/mstore_rowcol.sv
`timescale 1ns/1ps
module mstore_rowcol #(
  parameter int N   = 8,
  parameter int DW  = 16,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slice_col,
  input  logic [AW-1:0] slice_idx,
  input  logic          wr_en,
  input  logic [N*DW-1:0] wr_data,
  output logic [N*DW-1:0] rd_data
);
  import mstore_pkg::*;

  slice_dir_e             dir;
  logic [N-1:0][AW-1:0]   bank_addr;
  logic [N*DW-1:0]        bank_wdata;
  logic [N*DW-1:0]        bank_rdata;
  logic [AW-1:0]          idx_q;

  assign dir = slice_dir_e'(slice_col);

  mstore_addr #(.N(N)) i_addr (
    .dir  (dir),
    .idx  (slice_idx),
    .addr (bank_addr)
  );

  // Write side: lane k goes to bank (k+idx) mod N.
  mstore_rotate #(.N(N), .DW(DW), .GATHER(1'b0)) i_wr_rot (
    .din  (wr_data),
    .amt  (slice_idx),
    .dout (bank_wdata)
  );

  for (genvar b = 0; b < N; b++) begin : g_bank
    mstore_bank #(.DEPTH(N), .DW(DW)) i_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .addr  (bank_addr[b]),
      .we    (wr_en),
      .wdata (bank_wdata[b*DW +: DW]),
      .rdata (bank_rdata[b*DW +: DW])
    );
  end

  // Rotation amount follows the registered bank read by one cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= slice_idx;
  end

  mstore_rotate #(.N(N), .DW(DW), .GATHER(1'b1)) i_rd_rot (
    .din  (bank_rdata),
    .amt  (idx_q),
    .dout (rd_data)
  );
endmodule

// File: rtl/mstore_rowcol_chk.sv
`timescale 1ns/1ps
module mstore_rowcol_chk #(
  parameter int N   = 8,
  parameter int DW  = 16,
  localparam int AW = $clog2(N)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 slice_col,
  input logic [AW-1:0]        slice_idx,
  input logic                 wr_en,
  input logic [N*DW-1:0]      wr_data,
  input logic [N*DW-1:0]      rd_data,
  input logic [N-1:0][AW-1:0] bank_addr
);
  logic [N-1:0] addr_seen;
  always_comb begin
    addr_seen = '0;
    for (int b = 0; b < N; b++) addr_seen[bank_addr[b]] = 1'b1;
  end

  // R2, R5: a slice written in one cycle and requested in the next returns the written lanes.
  a_r2_write_then_read: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && slice_col == $past(slice_col) && slice_idx == $past(slice_idx))
    |=> rd_data == $past(wr_data, 2));

  // R7, R8: the same slice requested twice with no write between returns the same lanes.
  a_r8_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_en) && slice_col == $past(slice_col) && slice_idx == $past(slice_idx))
    |=> rd_data == $past(rd_data));

  // R9: a column access drives every address once across the banks.
  a_r9_col_addr_once: assert property (@(posedge clk) disable iff (!rst_n)
    slice_col |-> (&addr_seen));

  // R9: a row access drives the row index on every bank.
  for (genvar b = 0; b < N; b++) begin : g_row
    a_r9_row_addr: assert property (@(posedge clk) disable iff (!rst_n)
      !slice_col |-> bank_addr[b] == slice_idx);
  end

  // R1: read bus is zero while reset is held.
  always_comb begin
    if (!rst_n) a_r1_reset_zero: assert (rd_data == '0);
  end
endmodule

bind mstore_rowcol mstore_rowcol_chk #(.N(N), .DW(DW)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .slice_col (slice_col),
  .slice_idx (slice_idx),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .rd_data   (rd_data),
  .bank_addr (bank_addr)
);

// File: tb/test_mstore_rowcol.sv
`timescale 1ns/1ps
module test_mstore_rowcol;
  localparam int N  = 8;
  localparam int DW = 16;
  localparam int AW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          slice_col = 1'b0;
  logic [AW-1:0] slice_idx = '0;
  logic          wr_en = 1'b0;
  logic [N*DW-1:0] wr_data = '0;
  logic [N*DW-1:0] rd_data;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] model [N*N];

  always #5 clk = ~clk;

  mstore_rowcol #(.N(N), .DW(DW)) i_mstore_rowcol (
    .clk(clk), .rst_n(rst_n), .slice_col(slice_col), .slice_idx(slice_idx),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
  );

  function automatic logic [DW-1:0] pat(input int seed, input int r, input int c);
    return DW'(seed * 131 + r * 17 + c * 3 + 7);
  endfunction

  // Called at a negedge: drives one slice op, waits one cycle, checks the read of the
  // pre-write content (R7), then updates the model. Back-to-back calls use every cycle (R2).
  task automatic do_op(input bit col, input int idx, input bit we, input int seed,
                       input string req);
    logic [N*DW-1:0] wd;
    logic [N*DW-1:0] exp;
    for (int k = 0; k < N; k++) begin
      int r = col ? k : idx;
      int c = col ? idx : k;
      exp[k*DW +: DW] = model[r*N + c];
      wd[k*DW +: DW]  = pat(seed, r, c);
    end
    slice_col = col;
    slice_idx = AW'(idx);
    wr_en     = we;
    wr_data   = wd;
    @(negedge clk);
    checks++;
    if (rd_data !== exp) begin
      errors++;
      $display("FAIL %s: %s %0d actual %h expected %h", req, col ? "col" : "row", idx,
               rd_data, exp);
    end
    if (we) begin
      for (int k = 0; k < N; k++) begin
        int r = col ? k : idx;
        int c = col ? idx : k;
        model[r*N + c] = pat(seed, r, c);
      end
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    for (int e = 0; e < N*N; e++) model[e] = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (rd_data !== '0) begin
      errors++;
      $display("FAIL R1: reset read bus actual %h expected 0", rd_data);
    end
    rst_n = 1'b1;
    @(negedge clk);
    // R1: every slice reads zero after reset
    for (int i = 0; i < N; i++) do_op(1'b0, i, 1'b0, 0, "R1");
    for (int j = 0; j < N; j++) do_op(1'b1, j, 1'b0, 0, "R1");
    // R5, R7, R9: fill by rows back to back; each write also reads the old row
    for (int i = 0; i < N; i++) do_op(1'b0, i, 1'b1, 1, "R5");
    // R4, R6: column reads give the transpose view of the row writes
    for (int j = 0; j < N; j++) do_op(1'b1, j, 1'b0, 0, "R4");
    // R5, R7: overwrite by columns, reading each old column
    for (int j = N-1; j >= 0; j--) do_op(1'b1, j, 1'b1, 2, "R7");
    // R3, R6: row reads after column writes
    for (int i = 0; i < N; i++) do_op(1'b0, i, 1'b0, 0, "R3");
    // R7: same slice written twice in a row; second returns first's data
    do_op(1'b0, 3, 1'b1, 3, "R7");
    do_op(1'b0, 3, 1'b1, 4, "R7");
    do_op(1'b0, 3, 1'b0, 0, "R7");
    // R7: a column crossing the just-written row
    do_op(1'b1, 5, 1'b1, 5, "R7");
    do_op(1'b0, 3, 1'b0, 0, "R7");
    // R8: write bus toggling with wr_en low changes nothing
    for (int i = 0; i < N; i++) do_op(1'b0, i, 1'b0, 9 + i, "R8");
    for (int j = 0; j < N; j++) do_op(1'b1, j, 1'b0, 20 + j, "R8");
    for (int i = 0; i < N; i++) do_op(1'b0, i, 1'b0, 0, "R8");
    // R2, R9: pseudo-random mixed stream, one op per cycle
    lfsr = 16'hACE1;
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      do_op(lfsr[0], int'(lfsr[6:4]), lfsr[9], 100 + n, "R2");
    end
    for (int j = 0; j < N; j++) do_op(1'b1, j, 1'b0, 0, "R2");
    wr_en = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule